// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detect

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins, either 64 or 96. Every pin feature is held in a bank of 32-bit words, one word for each group of 32 pins. The banks sit one after another in a fixed feature order, so the address stride between features grows with the pin count. Software reads the synchronised pin levels and programs pin directions. It changes output values only through separate write-one-to-set and write-one-to-clear words. Each pin can be armed for rising edges, falling edges or both.

Armed edges are recorded in sticky status bits. Software clears a status bit by writing a one to it, so writing back a value it has just read clears exactly the bits it saw. A single interrupt line is raised while any status bit is set. Pin inputs are brought into the clock domain through two flops before they are used. The register port is a plain write strobe with an address. Read data is a combinational function of the address.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` all zero), every output value is zero, all edge enables and status bits are zero, and `irq` is low.
- R2: Feature index f runs 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 status. Pin p is controlled by bit p mod 32 of the word at byte address (f*NREG + p/32)*4, where NREG = NPINS/32.
- R3: Writing the set word drives high the output value of each pin whose data bit is 1. Pins whose data bit is 0 keep their value. The set word reads as zero.
- R4: Writing the clear word drives low the output value of each pin whose data bit is 1. Pins whose data bit is 0 keep their value. The clear word reads as zero.
- R5: A direction bit of 1 makes its pin an output (`pin_oe` high), 0 makes it an input. The direction word reads back as written.
- R6: The level word returns each pin input after a two-flop synchroniser. A change at `pin_in` is visible from the second rising clock edge after it. Writes to the level word change nothing.
- R7: With a pin's rising enable set, a 0-to-1 change of its synchronised level sets its status bit on the third rising clock edge after the input change. No status bit is set without an armed edge.
- R8: With the falling enable set, a 1-to-0 change sets the status bit. With both enables set, either edge sets it. With neither set, no edge is recorded.
- R9: Status bits stay set until a one is written to them in the status word. Zero data bits leave status bits unchanged.
- R10: When a new edge event and a write-one-to-clear of the same status bit fall in the same cycle, the bit stays set.
- R11: `irq` is high exactly while at least one status bit is set.
- R12: Byte addresses at or beyond 7*NREG*4 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Output value of each pin |
| pin_oe | output | NPINS | Output enable of each pin (1 = drive) |
| irq | output | 1 | OR of all edge status bits |

## Verification
The embedded properties check on every cycle that:
- output values and directions move only on writes to their own words;
- a set write actually raises the selected bits;
- status bits never drop without a one written to them;
- status bits never rise without an armed edge event;
- an event always wins over a clear landing in the same cycle.

Only the directed scenarios can show the rest:
- the address map, including the stride that depends on the pin count;
- the exact synchroniser and status latency, and that level writes are ignored;
- the read-as-zero words and out-of-range accesses;
- the behaviour of the interrupt output as seen from outside the block.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned NUM_FEAT = 7;

    // Feature order fixes the address map: index times NREG words.
    typedef enum logic [2:0] {
        FEAT_LEVEL = 3'd0,
        FEAT_DIR   = 3'd1,
        FEAT_SET   = 3'd2,
        FEAT_CLR   = 3'd3,
        FEAT_RISE  = 3'd4,
        FEAT_FALL  = 3'd5,
        FEAT_STAT  = 3'd6,
        FEAT_NONE  = 3'd7
    } feat_e;
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NREG   = 2,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned GRP_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output feat_e             feat,
    output logic [GRP_W-1:0]  grp
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    assign widx = addr[ADDR_W-1:2];

    always_comb begin
        feat = FEAT_NONE;
        grp  = '0;
        for (int f = 0; f < int'(NUM_FEAT); f++) begin
            for (int g = 0; g < int'(NREG); g++) begin
                if (int'(widx) == f * int'(NREG) + g) begin
                    feat = feat_e'(f[2:0]);
                    grp  = g[GRP_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int unsigned NPINS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] lvl,
    output logic [NPINS-1:0] lvl_prev
);
    typedef struct packed {
        logic [NPINS-1:0] meta;
        logic [NPINS-1:0] stab;
        logic [NPINS-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pin_in;
        s_d.stab = s_q.meta;
        s_d.prev = s_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl      = s_q.stab;
    assign lvl_prev = s_q.prev;

    // R6: the synchronised level follows the first stage one cycle later
    sync_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (s_q.stab == $past(s_q.meta)));
endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
    parameter int unsigned NPINS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] lvl_prev,
    input  logic [NPINS-1:0] rise_en,
    input  logic [NPINS-1:0] fall_en,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] status
);
    typedef struct packed {
        logic [NPINS-1:0] stat;
    } edge_t;

    edge_t e_d, e_q;
    logic [NPINS-1:0] evt;

    always_comb begin
        evt        = (lvl & ~lvl_prev & rise_en) | (~lvl & lvl_prev & fall_en);
        e_d        = e_q;
        // new event dominates a clear in the same cycle
        e_d.stat   = (e_q.stat & ~clr_mask) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign status = e_q.stat;

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(e_q.stat) & ~$past(clr_mask) & ~e_q.stat) == '0));
    // R7
    no_unarmed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((e_q.stat & ~$past(e_q.stat) & ~$past(evt)) == '0));
    // R10
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt) & ~e_q.stat) == '0));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 64,
    parameter int unsigned NREG  = 2,
    parameter int unsigned GRP_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  feat_e            feat,
    input  logic [GRP_W-1:0] grp,
    input  logic [WORD_W-1:0] wdata,
    output logic [NPINS-1:0] dir,
    output logic [NPINS-1:0] outv,
    output logic [NPINS-1:0] rise_en,
    output logic [NPINS-1:0] fall_en,
    output logic [NPINS-1:0] clr_mask
);
    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] outv;
        logic [NPINS-1:0] ren;
        logic [NPINS-1:0] fen;
    } regs_t;

    regs_t r_d, r_q;
    logic [NPINS-1:0] wmask;   // write data placed at its group
    logic [NPINS-1:0] gsel;    // ones over the addressed group

    always_comb begin
        wmask = '0;
        gsel  = '0;
        for (int g = 0; g < int'(NREG); g++) begin
            if (grp == g[GRP_W-1:0]) begin
                wmask[g*WORD_W +: WORD_W] = wdata;
                gsel[g*WORD_W +: WORD_W]  = '1;
            end
        end

        r_d      = r_q;
        clr_mask = '0;
        if (we) begin
            unique case (feat)
                FEAT_DIR:  r_d.dir  = (r_q.dir & ~gsel) | wmask;
                FEAT_SET:  r_d.outv = r_q.outv | wmask;
                FEAT_CLR:  r_d.outv = r_q.outv & ~wmask;
                FEAT_RISE: r_d.ren  = (r_q.ren & ~gsel) | wmask;
                FEAT_FALL: r_d.fen  = (r_q.fen & ~gsel) | wmask;
                FEAT_STAT: clr_mask = wmask;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dir     = r_q.dir;
    assign outv    = r_q.outv;
    assign rise_en = r_q.ren;
    assign fall_en = r_q.fen;

    // R3 R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (feat == FEAT_SET || feat == FEAT_CLR)) |=> $stable(r_q.outv));
    // R3
    set_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && feat == FEAT_SET) |=> ((r_q.outv & $past(wmask)) == $past(wmask)));
    // R5
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && feat == FEAT_DIR) |=> $stable(r_q.dir));
    // R8
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (feat == FEAT_RISE || feat == FEAT_FALL)) |=> ($stable(r_q.ren) && $stable(r_q.fen)));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS  = 64,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam int unsigned NREG  = NPINS / WORD_W;
    localparam int unsigned GRP_W = (NREG > 1) ? $clog2(NREG) : 1;

    feat_e            feat;
    logic [GRP_W-1:0] grp;
    logic [NPINS-1:0] lvl, lvl_prev, dir, outv, ren, fen, clr_mask, status;
    logic [NPINS-1:0] rsel;

    gpio_bank_decode #(.NREG(NREG), .ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_dec (
        .addr(bus_addr), .feat(feat), .grp(grp)
    );

    gpio_bank_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lvl(lvl), .lvl_prev(lvl_prev)
    );

    gpio_bank_regs #(.NPINS(NPINS), .NREG(NREG), .GRP_W(GRP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .feat(feat), .grp(grp),
        .wdata(bus_wdata), .dir(dir), .outv(outv), .rise_en(ren),
        .fall_en(fen), .clr_mask(clr_mask)
    );

    gpio_bank_edge #(.NPINS(NPINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .lvl_prev(lvl_prev),
        .rise_en(ren), .fall_en(fen), .clr_mask(clr_mask), .status(status)
    );

    always_comb begin
        unique case (feat)
            FEAT_LEVEL: rsel = lvl;
            FEAT_DIR:   rsel = dir;
            FEAT_RISE:  rsel = ren;
            FEAT_FALL:  rsel = fen;
            FEAT_STAT:  rsel = status;
            default:    rsel = '0;
        endcase
        bus_rdata = '0;
        for (int g = 0; g < int'(NREG); g++) begin
            if (grp == g[GRP_W-1:0]) bus_rdata = rsel[g*WORD_W +: WORD_W];
        end
    end

    assign pin_out = outv;
    assign pin_oe  = dir;
    assign irq     = |status;

    // R12
    range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) >= int'(NUM_FEAT * NREG * 4)) |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
    localparam int NPINS = 64;
    localparam int NREG  = NPINS / 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_we = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [NPINS-1:0] pin_in = '0;
    logic [NPINS-1:0] pin_out, pin_oe;
    logic             irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_bank_ctrl #(.NPINS(NPINS), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [7:0] adr(input int feat, input int grp);
        return 8'((feat * NREG + grp) * 4);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 oe", 64'(pin_oe), 64'h0);
        chk("R1 out", 64'(pin_out), 64'h0);
        chk("R1 irq", 64'(irq), 64'h0);
        for (int f = 1; f < 7; f++)
            for (int g = 0; g < NREG; g++) begin
                rd(adr(f, g), d);
                chk("R1 word", 64'(d), 64'h0);
            end
    endtask

    task automatic t_dir;
        logic [31:0] d;
        wr(adr(1, 1), 32'hA5A5_0003);   // R2: group 1 covers pins 32..63
        rd(adr(1, 1), d);
        chk("R5 readback", 64'(d), 64'hA5A5_0003);
        chk("R5 R2 oe", 64'(pin_oe), 64'hA5A5_0003_0000_0000);
        wr(adr(1, 0), 32'h0000_00F0);
        chk("R5 oe grp0", 64'(pin_oe), 64'hA5A5_0003_0000_00F0);
    endtask

    task automatic t_set_clr;
        logic [31:0] d;
        wr(adr(2, 0), 32'h0000_000F);
        chk("R3 set", 64'(pin_out), 64'h0000_0000_0000_000F);
        wr(adr(2, 1), 32'h8000_0000);
        chk("R3 R2 set high grp", 64'(pin_out), 64'h8000_0000_0000_000F);
        wr(adr(2, 0), 32'h0);
        chk("R3 zero write", 64'(pin_out), 64'h8000_0000_0000_000F);
        wr(adr(3, 0), 32'h0000_0005);
        chk("R4 clear", 64'(pin_out), 64'h8000_0000_0000_000A);
        wr(adr(3, 1), 32'h0);
        chk("R4 zero write", 64'(pin_out), 64'h8000_0000_0000_000A);
        rd(adr(2, 0), d);
        chk("R3 read zero", 64'(d), 64'h0);
        rd(adr(3, 1), d);
        chk("R4 read zero", 64'(d), 64'h0);
    endtask

    task automatic t_level;
        logic [31:0] d;
        @(negedge clk);
        pin_in = 64'h1234_5678_0000_0001;
        @(negedge clk);
        rd(adr(0, 0), d);
        chk("R6 one edge old", 64'(d), 64'h0);
        @(negedge clk);
        rd(adr(0, 0), d);
        chk("R6 grp0", 64'(d), 64'h0000_0001);
        rd(adr(0, 1), d);
        chk("R6 grp1", 64'(d), 64'h1234_5678);
        wr(adr(0, 0), 32'hFFFF_FFFF);
        rd(adr(0, 0), d);
        chk("R6 write ignored", 64'(d), 64'h0000_0001);
        chk("R6 write no out effect", 64'(pin_out), 64'h8000_0000_0000_000A);
        chk("R6 no status", 64'(irq), 64'h0);
        @(negedge clk);
        pin_in = '0;
        wait_neg(3);
    endtask

    task automatic t_edges;
        logic [31:0] d;
        wr(adr(4, 0), 32'h0000_0100);   // pin 8 rising
        wr(adr(5, 1), 32'h0000_0002);   // pin 33 falling
        rd(adr(4, 0), d);
        chk("R8 rise en readback", 64'(d), 64'h0000_0100);
        @(negedge clk);
        pin_in[8]  = 1'b1;
        pin_in[33] = 1'b1;   // rising on a falling-only pin
        pin_in[9]  = 1'b1;   // unarmed pin
        wait_neg(2);
        rd(adr(6, 0), d);
        chk("R7 not yet", 64'(d), 64'h0);
        @(negedge clk);
        rd(adr(6, 0), d);
        chk("R7 rise latched", 64'(d), 64'h0000_0100);
        rd(adr(6, 1), d);
        chk("R8 rise on fall-only", 64'(d), 64'h0);
        chk("R11 irq set", 64'(irq), 64'h1);
        @(negedge clk);
        pin_in[33] = 1'b0;
        pin_in[8]  = 1'b0;
        wait_neg(3);
        rd(adr(6, 1), d);
        chk("R8 fall latched", 64'(d), 64'h0000_0002);
        rd(adr(6, 0), d);
        chk("R9 still set", 64'(d), 64'h0000_0100);
        wr(adr(6, 0), 32'h0000_0001);   // clear a bit that is not set
        rd(adr(6, 0), d);
        chk("R9 zero bits keep", 64'(d), 64'h0000_0100);
        wr(adr(6, 0), 32'h0000_0100);
        rd(adr(6, 0), d);
        chk("R9 w1c", 64'(d), 64'h0);
        chk("R11 irq still (grp1)", 64'(irq), 64'h1);
        wr(adr(6, 1), 32'h0000_0002);
        chk("R11 irq low", 64'(irq), 64'h0);
    endtask

    task automatic t_both_and_race;
        logic [31:0] d;
        wr(adr(4, 0), 32'h0000_0020);
        wr(adr(5, 0), 32'h0000_0020);   // pin 5 both edges
        @(negedge clk);
        pin_in[5] = 1'b1;
        wait_neg(3);
        rd(adr(6, 0), d);
        chk("R8 both rise", 64'(d), 64'h0000_0020);
        // falling edge event coincides with the clear write
        @(negedge clk);
        pin_in[5] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = adr(6, 0); bus_wdata = 32'h0000_0020;
        @(negedge clk);
        bus_we = 1'b0;
        rd(adr(6, 0), d);
        chk("R10 event wins", 64'(d), 64'h0000_0020);
        chk("R10 irq", 64'(irq), 64'h1);
        wr(adr(6, 0), 32'h0000_0020);
        rd(adr(6, 0), d);
        chk("R8 R9 cleared", 64'(d), 64'h0);
        wr(adr(4, 0), 32'h0);
        wr(adr(5, 0), 32'h0);
        @(negedge clk);
        pin_in[5] = 1'b1;
        wait_neg(4);
        rd(adr(6, 0), d);
        chk("R8 disabled none", 64'(d), 64'h0);
    endtask

    task automatic t_range;
        logic [31:0] d;
        logic [63:0] oe_before, out_before;
        oe_before  = pin_oe;
        out_before = pin_out;
        wr(8'(7 * NREG * 4), 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'(7 * NREG * 4), d);
        chk("R12 read zero", 64'(d), 64'h0);
        rd(8'hFC, d);
        chk("R12 read zero top", 64'(d), 64'h0);
        chk("R12 oe unchanged", 64'(pin_oe), oe_before);
        chk("R12 out unchanged", 64'(pin_out), out_before);
        chk("R12 irq unchanged", 64'(irq), 64'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir();
        t_set_clr();
        t_level();
        t_edges();
        t_both_and_race();
        t_range();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule